// File: doc/BRIEF.md
# Timer Channel Status and Output Control

This block holds the control and status bits of one 8-bit timer channel and decides what reaches the channel's output pin. It keeps an event flag that the timer's match or overflow pulses set, depending on the selected function. Software clears the flag by writing zero to it. A read that is part of a read-modify-write access sees the flag as 1. Because of this, a bit-set or bit-clear operation on another field writes the 1 back, and that write leaves the flag alone.

The block also holds an initial-level bit for the timer waveform. That bit is copied into the output level register when the channel's start bit rises, and it cannot be written while the channel runs. While the channel runs, the output level follows the waveform that the counter supplies. An output-enable bit selects whether the pin carries that level or a general-purpose port value. When two channels are chained for 16-bit operation, the upper channel's flag is held clear. Its output level is also loaded from the lower channel's initial-level bit, and its own initial-level bit stays writable. The counter itself lives outside this block.

Top module: `tmr_ctl_status`

## Requirements
- R1: After reset the flag, initial-level bit, output-enable bit and output level are all 0, so the pin carries the general-purpose value.
- R2: The flag is set by a match pulse when the function select is 0 (one-shot interval) or 1 (continuous interval). It is set by an overflow pulse when the select is 4 (pulse width) or 5 (capture). Other pulses and the other codes (2 fixed PWM, 6, 7) leave it unchanged.
- R3: A write with bit 2 of the write data at 0 clears the flag. A write with bit 2 at 1 leaves the flag unchanged.
- R4: When a set event and a clearing write fall in the same cycle, the flag ends up 1.
- R5: The flag is forced to 0 when the function select is 3 (variable-cycle PWM), and in the upper-channel variant whenever the 16-bit input is 1.
- R6: While the read strobe and the read-modify-write indication are both high, read bit 2 returns 1 whatever the flag holds. On a plain read it returns the flag.
- R7: On the cycle after the start bit goes from 0 to 1, the output level equals the initial-level bit as it was before that edge.
- R8: A write to the initial-level bit (write bit 1) is ignored while the start bit is 1, except in the upper channel during 16-bit operation.
- R9: In the upper channel during 16-bit operation, the level loaded on a start rise is the lower channel's initial-level input, and the channel's own initial-level bit accepts writes while running.
- R10: While the start bit is 1, a cycle with the waveform-valid input high copies the waveform input into the output level. Without that strobe the level holds.
- R11: With the output-enable bit (write bit 0) at 1 the pin carries the output level. With it at 0 the pin carries the general-purpose value.
- R12: Read data carries output enable on bit 0, initial level on bit 1, flag on bit 2 and the start bit on bit 3, with all other bits 0. When the read strobe is low the read data is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | BUS_W | Write data |
| rdEn | input | 1 | Register read strobe |
| rmwRd | input | 1 | Read belongs to a read-modify-write access |
| rdData | output | BUS_W | Read data |
| startBit | input | 1 | Channel run bit |
| funcSel | input | 3 | Timer function select |
| wide16 | input | 1 | Two channels chained for 16-bit operation |
| peerInitVal | input | 1 | Lower channel's initial-level bit (used by the upper variant) |
| matchEvt | input | 1 | Count-equals-compare pulse |
| ovfEvt | input | 1 | Counter overflow pulse |
| waveIn | input | 1 | Waveform level from the counter |
| waveVld | input | 1 | Waveform level update strobe |
| gpioVal | input | 1 | General-purpose port value |
| flagOut | output | 1 | Event flag |
| pinOut | output | 1 | Pin drive |

## Verification
The bench builds two copies side by side at the default 8-bit bus width: one with IS_UPPER at 0 and one at 1. The same stimulus drives both, so every flag and initial-level rule is compared between the lower and upper variants. The flag is swept over every combination of prior value, all eight function codes, both 16-bit settings, all match and overflow pairs, and no write, a clearing write or a writing-one access. This reaches every case of the priority between the forced clear, a set event and a clearing write. Directed sequences cover start-edge loading, write locking while running, waveform tracking, the pin selection and the read layout.

// File: rtl/tmr_ctl_pkg.sv
package tmr_ctl_pkg;

  // Read/write layout of the channel control register
  localparam int OEN_POS   = 0;
  localparam int INIT_POS  = 1;
  localparam int FLAG_POS  = 2;
  localparam int START_POS = 3;
  localparam int FUNC_W    = 3;

  typedef enum logic [FUNC_W-1:0] {
    FN_IVL_ONE  = 3'd0,
    FN_IVL_CONT = 3'd1,
    FN_PWM_FIX  = 3'd2,
    FN_PWM_VAR  = 3'd3,
    FN_PWC      = 3'd4,
    FN_CAPT     = 3'd5,
    FN_RSV6     = 3'd6,
    FN_RSV7     = 3'd7
  } func_e;

  // Strobes from the control decode to the register datapath
  typedef struct packed {
    logic setFlag;
    logic clrFlag;
    logic forceZero;
    logic wrInit;
    logic wrOutEn;
    logic startRise;
    logic useWave;
    logic usePeer;
  } ctl_strb_t;

endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
  import tmr_ctl_pkg::*;
#(
  parameter int IS_UPPER = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrFlagBit,
  input  logic              startBit,
  input  logic [FUNC_W-1:0] funcSel,
  input  logic              wide16,
  input  logic              matchEvt,
  input  logic              ovfEvt,
  input  logic              waveVld,
  output ctl_strb_t         strb
);

  localparam logic UPPER = (IS_UPPER != 0);

  logic  startQ;
  logic  sharedHi;
  logic  modeSet;
  func_e fn;

  assign fn       = func_e'(funcSel);
  assign sharedHi = UPPER & wide16;

  always_ff @(posedge clk) begin
    if (!rstN) startQ <= 1'b0;
    else       startQ <= startBit;
  end

  always_comb begin
    unique case (fn)
      FN_IVL_ONE, FN_IVL_CONT: modeSet = matchEvt;
      FN_PWC, FN_CAPT:         modeSet = ovfEvt;
      default:                 modeSet = 1'b0;
    endcase
  end

  always_comb begin
    strb           = '0;
    strb.setFlag   = modeSet;
    strb.clrFlag   = wrEn & ~wrFlagBit;
    strb.forceZero = (fn == FN_PWM_VAR) | sharedHi;
    strb.wrInit    = wrEn & (~startBit | sharedHi);
    strb.wrOutEn   = wrEn;
    strb.startRise = startBit & ~startQ;
    strb.useWave   = startBit & waveVld;
    strb.usePeer   = sharedHi;
  end

  // R7: a start edge is a single-cycle strobe
  p_rise_once_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.startRise |=> !strb.startRise);

endmodule

// File: rtl/tmr_ctl_regs.sv
module tmr_ctl_regs
  import tmr_ctl_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_strb_t        strb,
  input  logic             wrInitBit,
  input  logic             wrOenBit,
  input  logic             rdEn,
  input  logic             rmwRd,
  input  logic             startBit,
  input  logic             peerInitVal,
  input  logic             waveIn,
  input  logic             gpioVal,
  output logic [BUS_W-1:0] rdData,
  output logic             flagOut,
  output logic             pinOut
);

  logic             flagQ;
  logic             initQ;
  logic             oenQ;
  logic             levelQ;
  logic [BUS_W-1:0] rdVal;

  always_ff @(posedge clk) begin
    if (!rstN)               flagQ <= 1'b0;
    else if (strb.forceZero) flagQ <= 1'b0;
    else if (strb.setFlag)   flagQ <= 1'b1;
    else if (strb.clrFlag)   flagQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initQ <= 1'b0;
      oenQ  <= 1'b0;
    end else begin
      if (strb.wrInit)  initQ <= wrInitBit;
      if (strb.wrOutEn) oenQ  <= wrOenBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               levelQ <= 1'b0;
    else if (strb.startRise) levelQ <= strb.usePeer ? peerInitVal : initQ;
    else if (strb.useWave)   levelQ <= waveIn;
  end

  always_comb begin
    rdVal            = '0;
    rdVal[OEN_POS]   = oenQ;
    rdVal[INIT_POS]  = initQ;
    rdVal[FLAG_POS]  = flagQ | rmwRd;
    rdVal[START_POS] = startBit;
    rdData           = rdEn ? rdVal : '0;
  end

  assign flagOut = flagQ;
  assign pinOut  = oenQ ? levelQ : gpioVal;

  p_forced_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceZero |=> !flagQ);

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setFlag && !strb.forceZero) |=> flagQ);

  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrFlag && !strb.setFlag && !strb.forceZero) |=> !flagQ);

  p_flag_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clrFlag && !strb.setFlag && !strb.forceZero) |=> $stable(flagQ));

  p_init_lock_r8: assert property (@(posedge clk) disable iff (!rstN)
    (startBit && !strb.usePeer) |=> $stable(initQ));

  p_start_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.startRise && !strb.usePeer) |=> (levelQ == $past(initQ)));

  p_peer_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.startRise && strb.usePeer) |=> (levelQ == $past(peerInitVal)));

  p_wave_follow_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.useWave && !strb.startRise) |=> (levelQ == $past(waveIn)));

endmodule

// File: rtl/tmr_ctl_status.sv
module tmr_ctl_status
  import tmr_ctl_pkg::*;
#(
  parameter int BUS_W    = 8,
  parameter int IS_UPPER = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [BUS_W-1:0]  wrData,
  input  logic              rdEn,
  input  logic              rmwRd,
  output logic [BUS_W-1:0]  rdData,
  input  logic              startBit,
  input  logic [FUNC_W-1:0] funcSel,
  input  logic              wide16,
  input  logic              peerInitVal,
  input  logic              matchEvt,
  input  logic              ovfEvt,
  input  logic              waveIn,
  input  logic              waveVld,
  input  logic              gpioVal,
  output logic              flagOut,
  output logic              pinOut
);

  ctl_strb_t strb;
  logic      unusedWrBits;

  assign unusedWrBits = ^wrData;

  tmr_ctl_decode #(
    .IS_UPPER (IS_UPPER)
  ) u_decode (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrFlagBit (wrData[FLAG_POS]),
    .startBit  (startBit),
    .funcSel   (funcSel),
    .wide16    (wide16),
    .matchEvt  (matchEvt),
    .ovfEvt    (ovfEvt),
    .waveVld   (waveVld),
    .strb      (strb)
  );

  tmr_ctl_regs #(
    .BUS_W (BUS_W)
  ) u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrInitBit   (wrData[INIT_POS]),
    .wrOenBit    (wrData[OEN_POS]),
    .rdEn        (rdEn),
    .rmwRd       (rmwRd),
    .startBit    (startBit),
    .peerInitVal (peerInitVal),
    .waveIn      (waveIn),
    .gpioVal     (gpioVal),
    .rdData      (rdData),
    .flagOut     (flagOut),
    .pinOut      (pinOut)
  );

endmodule

// File: tb/tmr_ctl_status_bench.sv
`timescale 1ns/1ps
module tmr_ctl_status_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0, rmwRd = 1'b0;
  logic [7:0] wrData = '0;
  logic       startBit = 1'b0, wide16 = 1'b0, peerInitVal = 1'b0;
  logic [2:0] funcSel = '0;
  logic       matchEvt = 1'b0, ovfEvt = 1'b0, waveIn = 1'b0, waveVld = 1'b0, gpioVal = 1'b0;
  logic [7:0] rdLo, rdHi;
  logic       flagLo, flagHi, pinLo, pinHi;
  int         nChecks = 0, nFail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  tmr_ctl_status #(.BUS_W(8), .IS_UPPER(0)) u_tmr_ctl_status (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rmwRd(rmwRd),
    .rdData(rdLo), .startBit(startBit), .funcSel(funcSel), .wide16(wide16),
    .peerInitVal(peerInitVal), .matchEvt(matchEvt), .ovfEvt(ovfEvt), .waveIn(waveIn),
    .waveVld(waveVld), .gpioVal(gpioVal), .flagOut(flagLo), .pinOut(pinLo));

  tmr_ctl_status #(.BUS_W(8), .IS_UPPER(1)) u_tmr_ctl_status_hi (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rmwRd(rmwRd),
    .rdData(rdHi), .startBit(startBit), .funcSel(funcSel), .wide16(wide16),
    .peerInitVal(peerInitVal), .matchEvt(matchEvt), .ovfEvt(ovfEvt), .waveIn(waveIn),
    .waveVld(waveVld), .gpioVal(gpioVal), .flagOut(flagHi), .pinOut(pinHi));

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // write layout: bit0 output enable, bit1 initial level, bit2 flag
  task automatic writeReg(input bit oen, input bit init, input bit flg);
    wrData = {5'b0, flg, init, oen};
    wrEn   = 1'b1;
    @(negedge clk);
    wrEn   = 1'b0;
    wrData = '0;
  endtask

  function automatic bit expFlag(bit p, int m, bit w, bit mt, bit ov, int c, bit up);
    bit forced = (m == 3) || (up && w);
    bit set    = ((m == 0 || m == 1) && mt) || ((m == 4 || m == 5) && ov);
    if (forced) return 1'b0;
    if (set) return 1'b1;
    if (c == 1) return 1'b0;
    return p;
  endfunction

  function automatic string flagReq(int m, bit w, bit mt, bit ov, int c, bit up);
    bit forced = (m == 3) || (up && w);
    bit set    = ((m == 0 || m == 1) && mt) || ((m == 4 || m == 5) && ov);
    if (forced) return "R5";
    if (set && c == 1) return "R4";
    if (set) return "R2";
    return "R3";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    rstN    = 1'b1;
    gpioVal = 1'b1;
    rdEn    = 1'b1;
    #1;
    chk("R1 read lo", rdLo, 0);
    chk("R1 read hi", rdHi, 0);
    chk("R1 flag lo", flagLo, 0);
    chk("R1 pin gpio", pinLo, 1);
    writeReg(1'b1, 1'b0, 1'b1);
    chk("R1 level lo", pinLo, 0);
    chk("R1 level hi", pinHi, 0);
    chk("R3 write one keeps flag", flagLo, 0);
    rdEn = 1'b0;

    // R2..R5: flag sweep
    for (int p = 0; p < 2; p++)
      for (int m = 0; m < 8; m++)
        for (int w = 0; w < 2; w++)
          for (int e = 0; e < 4; e++)
            for (int c = 0; c < 3; c++) begin
              funcSel  = 3'd0;
              wide16   = 1'b0;
              matchEvt = 1'b1;
              @(negedge clk);
              matchEvt = 1'b0;
              if (p == 0) writeReg(1'b0, 1'b0, 1'b0);
              funcSel  = 3'(m);
              wide16   = w[0];
              matchEvt = e[0];
              ovfEvt   = e[1];
              if (c > 0) begin
                wrEn   = 1'b1;
                wrData = {5'b0, (c == 2), 2'b00};
              end
              @(negedge clk);
              wrEn = 1'b0; wrData = '0; matchEvt = 1'b0; ovfEvt = 1'b0;
              funcSel = 3'd0; wide16 = 1'b0;
              chk(flagReq(m, w[0], e[0], e[1], c, 1'b0), flagLo,
                  expFlag(p[0], m, w[0], e[0], e[1], c, 1'b0));
              chk(flagReq(m, w[0], e[0], e[1], c, 1'b1), flagHi,
                  expFlag(p[0], m, w[0], e[0], e[1], c, 1'b1));
            end

    // fresh reset for directed sequences
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    gpioVal = 1'b0;

    writeReg(1'b1, 1'b1, 1'b1);
    rdEn = 1'b1;
    #1;
    chk("R12 layout idle", rdLo, 3);
    startBit = 1'b1;
    @(negedge clk);
    chk("R7 start load lo", pinLo, 1);
    chk("R7 start load hi", pinHi, 1);
    chk("R12 layout running", rdLo, 11);

    writeReg(1'b1, 1'b0, 1'b1);
    chk("R8 locked lo", rdLo, 11);
    chk("R8 locked hi narrow", rdHi, 11);
    wide16 = 1'b1;
    writeReg(1'b1, 1'b0, 1'b1);
    chk("R8 locked lo wide", rdLo, 11);
    chk("R9 hi writable running", rdHi, 9);

    waveIn = 1'b0; waveVld = 1'b1;
    @(negedge clk);
    waveVld = 1'b0;
    chk("R10 follow low lo", pinLo, 0);
    chk("R10 follow low hi", pinHi, 0);
    waveIn = 1'b1; waveVld = 1'b1;
    @(negedge clk);
    waveVld = 1'b0; waveIn = 1'b0;
    chk("R10 follow high", pinLo, 1);
    @(negedge clk);
    chk("R10 hold without strobe", pinLo, 1);

    startBit = 1'b0;
    @(negedge clk);
    writeReg(1'b1, 1'b0, 1'b1);
    peerInitVal = 1'b1;
    startBit    = 1'b1;
    @(negedge clk);
    chk("R7 start load zero lo", pinLo, 0);
    chk("R9 peer load hi", pinHi, 1);

    // R11: pin selection
    writeReg(1'b0, 1'b0, 1'b1);
    for (int g = 0; g < 2; g++) begin
      gpioVal = g[0];
      #1;
      chk("R11 gpio lo", pinLo, g);
      chk("R11 gpio hi", pinHi, g);
      @(negedge clk);
    end
    writeReg(1'b1, 1'b0, 1'b1);
    chk("R11 level lo", pinLo, 0);
    chk("R11 level hi", pinHi, 1);

    // R6 / R12: read variants
    rmwRd = 1'b1;
    #1;
    chk("R6 rmw flag seen set", rdLo, 13);
    rmwRd = 1'b0;
    #1;
    chk("R6 plain read", rdLo, 9);
    rdEn = 1'b0;
    #1;
    chk("R12 idle read zero", rdLo, 0);
    wide16 = 1'b0;
    matchEvt = 1'b1;
    @(negedge clk);
    matchEvt = 1'b0;
    rdEn = 1'b1;
    #1;
    chk("R6 plain read set flag", rdLo, 13);
    rdEn = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule